// File: doc/BRIEF.md
# Configurable Serial Character Transmit Framer

This block turns one character at a time into an asynchronous serial frame on a single line that rests high. The frame has a start bit, five to eight data bits, an optional parity bit and a stop period. An 8-bit line control value sets the frame shape. Bit time is counted in sub-bit ticks from an external tick input, normally sixteen per bit, so the block can produce a stop period of one and a half bits.

A character enters on a valid/ready handshake. A transfer takes place on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from that edge until the last tick of the stop period has been consumed. A producer that finds `in_ready` low keeps `in_valid` and `in_data` steady and waits. `line_ctrl` is captured at the same edge as the character and has no effect on a frame already in flight. `line_idle` reports that no frame is on the line and no request is waiting.

The line control fields are: bits [1:0] word length, bit 2 stop select, bit 3 parity enable, bit 4 parity sense. Bits [7:5] are unused.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset `in_ready` is 1, `txd` is 1 and `line_idle` is 1 while `in_valid` is 0.
- R2: A character is accepted on an edge with `in_valid` and `in_ready` both high. `in_ready` is 0 from the next cycle until the final stop tick has been consumed, and returns to 1 in the cycle after that tick.
- R3: Every frame starts with a low start bit lasting TICKS_PER_BIT ticks. The data bits follow, least significant bit first, each lasting TICKS_PER_BIT ticks.
- R4: `line_ctrl[1:0]` sets the data bit count: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8. Data bits above that count are not sent.
- R5: When `line_ctrl[3]` is 1, one parity bit of TICKS_PER_BIT ticks is sent after the last data bit and before the stop period.
- R6: With parity on, `line_ctrl[4]` = 0 makes the number of ones across the data and parity bits odd. `line_ctrl[4]` = 1 makes that number even.
- R7: When `line_ctrl[3]` is 0, no parity bit is sent and `line_ctrl[4]` has no effect on the line.
- R8: When `line_ctrl[2]` is 0, the line is high for TICKS_PER_BIT ticks of stop.
- R9: When `line_ctrl[2]` is 1 with a 6, 7 or 8-bit word length, the stop period lasts 2*TICKS_PER_BIT ticks.
- R10: When `line_ctrl[2]` is 1 with a 5-bit word length, the stop period lasts TICKS_PER_BIT + TICKS_PER_BIT/2 ticks.
- R11: `line_ctrl` and `in_data` are sampled at acceptance. Changing them during a frame does not alter that frame.
- R12: `line_idle` is 1 only when no frame is active and `in_valid` is 0.
- R13: `txd` is 1 whenever no frame is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at the sub-bit rate |
| line_ctrl | input | 8 | Frame shape: length, stop select, parity enable, parity sense |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | Character request |
| in_ready | output | 1 | Block can accept a character |
| line_idle | output | 1 | No frame active and no request waiting |
| txd | output | 1 | Serial output line, high at rest |

## Verification
The bench builds the framer with TICKS_PER_BIT = 8. This makes frames short enough to cover every word length, all four parity settings and all three stop lengths in a few thousand cycles. It also keeps the half-bit stop at a 4-tick boundary, where an off-by-one in the stop limit shows up at once. The bench pulses `baud_tick` once every three clocks. This puts idle clock cycles between ticks, so a design that counts clocks instead of ticks, or that counts the tick on the acceptance edge, gives the wrong edge positions. For each frame the bench works out the expected line level for every tick and compares against it tick by tick.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Field positions inside the line control value
  localparam int LC_LEN_LO  = 0;
  localparam int LC_STOP    = 2;
  localparam int LC_PAR_ON  = 3;
  localparam int LC_PAR_EVN = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP
  } tx_phase_e;

  typedef struct packed {
    logic [3:0] nbits;     // 5..8 data bits
    logic       par_on;
    logic       par_even;
    logic       stop_long; // stop select
  } frame_cfg_t;

endpackage

// File: rtl/uart_tx_cfg.sv
module uart_tx_cfg
  import uart_tx_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              hold_chk,
  input  logic [CTRL_W-1:0] ctrl,
  output frame_cfg_t        cfg_q
);

  frame_cfg_t cfg_d;

  always_comb begin
    cfg_d.nbits     = 4'd5 + {2'b00, ctrl[LC_LEN_LO +: 2]};
    cfg_d.par_on    = ctrl[LC_PAR_ON];
    cfg_d.par_even  = ctrl[LC_PAR_EVN];
    cfg_d.stop_long = ctrl[LC_STOP];
  end

  // The control value resets to 00h, so the reset frame shape is 5 bits, no parity, 1 stop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{nbits: 4'd5, par_on: 1'b0, par_even: 1'b0, stop_long: 1'b0};
    end else if (load) begin
      cfg_q <= cfg_d;
    end
  end

  // R11: the captured shape does not move while a frame is in flight
  assert_cfg_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_chk && $past(hold_chk)) |-> $stable(cfg_q));

  // R4: the captured length is always within 5..8
  assert_len_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.nbits >= 4'd5) && (cfg_q.nbits <= 4'd8));

endmodule

// File: rtl/uart_tx_timer.sv
module uart_tx_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  assign last = run && tick && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || last) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R3: the sub-bit count never passes the length of the current slot
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < limit));

  // R2: a stopped timer restarts from zero
  assert_cnt_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int CNT_W         = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data_in,
  input  frame_cfg_t        cfg,
  input  logic              slot_done,
  output tx_phase_e         phase,
  output logic [CNT_W-1:0]  limit,
  output logic              level
);

  localparam int IDX_W       = $clog2(DATA_W);
  localparam int STOP_ONE    = TICKS_PER_BIT;
  localparam int STOP_HALF   = TICKS_PER_BIT + TICKS_PER_BIT / 2;
  localparam int STOP_TWO    = 2 * TICKS_PER_BIT;

  logic [DATA_W-1:0] shreg;
  logic [IDX_W-1:0]  bit_idx;
  logic              par_q;
  logic              last_data;

  assign last_data = ({{(4-IDX_W){1'b0}}, bit_idx} == cfg.nbits - 4'd1);

  // Slot length depends on the phase; stop length on stop select and word length
  always_comb begin
    limit = CNT_W'(TICKS_PER_BIT);
    if (phase == PH_STOP) begin
      if (!cfg.stop_long)          limit = CNT_W'(STOP_ONE);
      else if (cfg.nbits == 4'd5)  limit = CNT_W'(STOP_HALF);
      else                         limit = CNT_W'(STOP_TWO);
    end
  end

  always_comb begin
    unique case (phase)
      PH_START:  level = 1'b0;
      PH_DATA:   level = shreg[0];
      PH_PARITY: level = par_q;
      default:   level = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
      par_q   <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_START;
            shreg   <= data_in;
            bit_idx <= '0;
          end
        end
        PH_START: begin
          if (slot_done) begin
            phase <= PH_DATA;
            par_q <= ~cfg.par_even; // odd sense seeds a one
          end
        end
        PH_DATA: begin
          if (slot_done) begin
            par_q   <= par_q ^ shreg[0];
            shreg   <= shreg >> 1;
            bit_idx <= bit_idx + IDX_W'(1);
            if (last_data) phase <= cfg.par_on ? PH_PARITY : PH_STOP;
          end
        end
        PH_PARITY: begin
          if (slot_done) phase <= PH_STOP;
        end
        PH_STOP: begin
          if (slot_done) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R5 / R7: the parity slot is entered only when parity is enabled
  assert_parity_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PARITY) |-> cfg.par_on);

  // R7: with parity off, data hands straight over to stop
  assert_no_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_DATA && phase != PH_DATA && !cfg.par_on) |-> (phase == PH_STOP));

  // R10: the stop slot length is one of the three legal values
  assert_stop_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STOP) |-> (limit == CNT_W'(STOP_ONE) || limit == CNT_W'(STOP_HALF)
                            || limit == CNT_W'(STOP_TWO)));

  // R9: a long stop of two bits is never chosen for 5-bit words
  assert_stop_two_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STOP && limit == CNT_W'(STOP_TWO)) |-> (cfg.nbits != 4'd5 && cfg.stop_long));

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8,
  parameter int CTRL_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [CTRL_W-1:0] line_ctrl,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              line_idle,
  output logic              txd
);

  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT) + 1;

  frame_cfg_t       cfg_q;
  tx_phase_e        phase;
  logic [CNT_W-1:0] limit;
  logic             slot_done;
  logic             accept;
  logic             active;

  assign active    = (phase != PH_IDLE);
  assign in_ready  = !active;
  assign accept    = in_valid && in_ready;
  assign line_idle = in_ready && !in_valid;

  uart_tx_cfg #(.CTRL_W(CTRL_W)) i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .hold_chk (active),
    .ctrl     (line_ctrl),
    .cfg_q    (cfg_q)
  );

  uart_tx_timer #(.CNT_W(CNT_W)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (active),
    .tick  (baud_tick),
    .limit (limit),
    .last  (slot_done)
  );

  uart_tx_seq #(
    .DATA_W        (DATA_W),
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .CNT_W         (CNT_W)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .data_in   (in_data),
    .cfg       (cfg_q),
    .slot_done (slot_done),
    .phase     (phase),
    .limit     (limit),
    .level     (txd)
  );

  // R2 / R3: acceptance drops ready and drives the start bit next cycle
  assert_accept_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !txd));

  // R13: the line rests high whenever ready
  assert_idle_mark_R13: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> txd);

  // R12: idle never reported while a request waits
  assert_idle_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !line_idle);

  // R2: ready returns only after a stop slot completes
  assert_ready_return_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> ($past(phase) == PH_STOP && $past(slot_done)));

endmodule

// File: tb/test_uart_tx_framer.sv
`timescale 1ns/1ps
module test_uart_tx_framer;

  localparam int TPB    = 8;
  localparam int MAXT   = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [7:0] line_ctrl = 8'h00;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready, line_idle, txd;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic exp_w [MAXT];

  always #4 clk = ~clk;

  uart_tx_framer #(.TICKS_PER_BIT(TPB)) i_uart_tx_framer (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .line_ctrl(line_ctrl),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .line_idle(line_idle), .txd(txd)
  );

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 3;
      baud_tick = (ph == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Build the expected per-tick line level and return the tick count
  function automatic int build(input logic [7:0] ctrl, input logic [7:0] d);
    int n = 0;
    int nb = 5 + ctrl[1:0];
    int stp;
    logic x = 1'b0;
    for (int t = 0; t < TPB; t++) exp_w[n++] = 1'b0;
    for (int b = 0; b < nb; b++) begin
      x ^= d[b];
      for (int t = 0; t < TPB; t++) exp_w[n++] = d[b];
    end
    if (ctrl[3]) for (int t = 0; t < TPB; t++) exp_w[n++] = ctrl[4] ? x : ~x;
    stp = !ctrl[2] ? TPB : (nb == 5 ? TPB + TPB / 2 : 2 * TPB);
    for (int t = 0; t < stp; t++) exp_w[n++] = 1'b1;
    return n;
  endfunction

  task automatic send_frame(input logic [7:0] ctrl, input logic [7:0] d,
                            input logic [7:0] ctrl_late, input string req);
    int n;
    int k = 0;
    int bad_tick = -1;
    int got = 0;
    bit rdy_bad = 1'b0;
    n = build(ctrl, d);
    step();
    while (!in_ready) step();
    line_ctrl = ctrl; in_data = d; in_valid = 1'b1;
    #1;
    check(!line_idle && in_ready, {req, " R12 idle low with request"}, line_idle, 0);
    step();
    in_valid = 1'b0; line_ctrl = ctrl_late; in_data = ~d;
    while (k < n) begin
      if (in_ready) rdy_bad = 1'b1;
      if (baud_tick) begin
        if (txd !== exp_w[k] && bad_tick < 0) begin bad_tick = k; got = txd; end
        k++;
      end
      if (k < n) step();
    end
    check(bad_tick < 0, {req, " line waveform tick mismatch"}, got,
          bad_tick < 0 ? 0 : int'(exp_w[bad_tick]));
    check(!rdy_bad, {req, " R2 ready low during frame"}, rdy_bad, 0);
    step();
    check(in_ready && txd && line_idle, {req, " R2 R13 ready and mark after last stop tick"},
          {in_ready, txd, line_idle}, 7);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    check(in_ready && txd && line_idle, "R1 reset state", {in_ready, txd, line_idle}, 7);
    rst_n = 1'b1;
    step();
    check(in_ready && txd, "R1 after release", {in_ready, txd}, 3);
  endtask

  task automatic t_lengths();
    send_frame(8'h00, 8'hE5, 8'h00, "R3 R4 5-bit");
    send_frame(8'h01, 8'hC6, 8'h01, "R4 6-bit");
    send_frame(8'h02, 8'hB3, 8'h02, "R4 7-bit");
    send_frame(8'h03, 8'h5A, 8'h03, "R3 R4 8-bit");
  endtask

  task automatic t_parity();
    send_frame(8'h0B, 8'h37, 8'h0B, "R5 R6 odd sense");
    send_frame(8'h1B, 8'h37, 8'h1B, "R5 R6 even sense");
    send_frame(8'h18, 8'h00, 8'h18, "R6 even zero data");
    send_frame(8'h13, 8'h81, 8'h13, "R7 parity off sense ignored");
  endtask

  task automatic t_stops();
    send_frame(8'h03, 8'hFF, 8'h03, "R8 one stop");
    send_frame(8'h07, 8'h0F, 8'h07, "R9 two stop 8-bit");
    send_frame(8'h05, 8'h21, 8'h05, "R9 two stop 6-bit");
    send_frame(8'h04, 8'h15, 8'h04, "R10 one and half stop");
    send_frame(8'h0C, 8'h0A, 8'h0C, "R10 half stop with parity");
  endtask

  task automatic t_hold();
    send_frame(8'h04, 8'h12, 8'hFB, "R11 shape held");
    send_frame(8'h1F, 8'h6C, 8'h00, "R11 shape held parity");
  endtask

  task automatic t_idle();
    step();
    check(line_idle, "R12 idle with no request", line_idle, 1);
  endtask

  initial begin
    t_reset();
    t_lengths();
    t_parity();
    t_stops();
    t_hold();
    t_idle();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule